// File: doc/BRIEF.md
# Byte-Wide GPIO Port with Read-Modify-Write Bit Sequencer

This block is an 8-bit general-purpose I/O port. A direction register and a data latch sit behind a small byte-wide register bus. Each direction bit selects whether its pin is driven from the latch or left undriven as an input. Input levels pass through a two-flop synchroniser before they reach the read path. A read of the data address returns a mixed byte: the latch value for output bits and the synchronised pin level for input bits.

A single-bit set or clear is not a masked write. A sequencer carries it out in three phases. First it reads the mixed port byte. Next it forces the selected bit. Last it writes the whole byte back into the latch. Because input bits are read from the pins, any such operation replaces the stored latch bits of every input pin with the levels sampled on those pins. The block models this hazard on purpose. Software that later turns an input into an output sees a latch value it never wrote.

Top module: `gpio_rmw_port`

## Requirements
- R1: After synchronous reset the direction and latch registers hold 0x00, `pin_oe` and `pin_out` are 0x00, `cmd_busy` is low, and a direction read returns 0x00.
- R2: `pin_oe` equals the direction register. `pin_out` carries the latch bit for every bit whose direction is 1 and is 0 for every bit whose direction is 0, whatever that latch bit holds.
- R3: A bus write with `bus_addr` = 0 (data latch) or 1 (direction) takes effect at the clock edge that samples it. A read strobe loads `bus_rdata` at that edge, and a direction read returns the stored direction byte.
- R4: A read of address 0 returns, for each bit, the latch bit where the direction is 1 and the synchronised pin level where the direction is 0.
- R5: A change on `pin_in` is invisible to reads sampled at the first two rising edges after it, and it is returned by a read sampled at the third.
- R6: An accepted command reads the mixed port byte, forces bit `cmd_bit` to `cmd_set` (1 = set, 0 = clear), and writes the whole byte into the latch.
- R7: With latch 0x80, direction 0x3F and pins 7 low and 6 high, setting bit 0 leaves the latch at 0x41. It drives pin 0 high and pins 5..1 low.
- R8: `cmd_busy` is high for exactly three cycles, starting with the cycle after acceptance. The latch is updated at the edge where `cmd_busy` falls.
- R9: A `cmd_valid` seen while `cmd_busy` is high is ignored and has no effect on the latch.
- R10: When a bus data write coincides with the sequencer's write phase, the sequencer result is stored and the bus data is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr_en | input | 1 | Register write strobe |
| bus_rd_en | input | 1 | Register read strobe |
| bus_addr | input | 1 | 0 = data latch, 1 = direction |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| cmd_valid | input | 1 | Bit command request |
| cmd_set | input | 1 | 1 = set bit, 0 = clear bit |
| cmd_bit | input | 3 | Bit index for the command |
| cmd_busy | output | 1 | Sequencer active |
| pin_in | input | 8 | External pin levels (asynchronous) |
| pin_out | output | 8 | Pin drive values |
| pin_oe | output | 8 | Pin drive enables (1 = driven) |

## Verification
The assertions assume the following about the inputs:
- Reset is held for at least one edge before any traffic.
- `cmd_bit` is always a valid index.
- At most one bus strobe type is active at a time, so a read and a write never share a cycle.

The bench drives each strobe for exactly one cycle from tasks that raise one signal at a time. It changes `pin_in` only at falling edges. It waits out the synchroniser latency before issuing a command, so the value the sequencer reads is the settled pin level. Collisions are created only where a requirement asks for them: a bus data write in the write phase, and a repeated command while busy.

// File: rtl/gpio_rmw_pkg.sv
package gpio_rmw_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE   = 2'd0,
    SQ_READ   = 2'd1,
    SQ_MODIFY = 2'd2,
    SQ_WRITE  = 2'd3
  } seq_state_t;

  localparam logic ADDR_DATA = 1'b0;
  localparam logic ADDR_DIR  = 1'b1;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [STAGES-1:0][WIDTH-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '0;
    else     stg[0] <= async_in;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[s] <= '0;
      else     stg[s] <= stg[s-1];
    end
  end

  assign sync_out = stg[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_rmw_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_wr_en,
  input  logic             bus_addr,
  input  logic [WIDTH-1:0] bus_wdata,
  input  logic             seq_wr,
  input  logic [WIDTH-1:0] seq_data,
  output logic [WIDTH-1:0] dir_q,
  output logic [WIDTH-1:0] latch_q
);
  always_ff @(posedge clk) begin
    if (rst)                                       dir_q <= '0;
    else if (bus_wr_en && bus_addr == ADDR_DIR)    dir_q <= bus_wdata;
  end

  // Sequencer write phase outranks a bus data write in the same cycle.
  always_ff @(posedge clk) begin
    if (rst)                                       latch_q <= '0;
    else if (seq_wr)                               latch_q <= seq_data;
    else if (bus_wr_en && bus_addr == ADDR_DATA)   latch_q <= bus_wdata;
  end

  a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (dir_q == '0 && latch_q == '0));

  a_r3_dir_write: assert property (@(posedge clk) disable iff (rst)
    (bus_wr_en && bus_addr == ADDR_DIR) |=> dir_q == $past(bus_wdata));

  a_r3_data_write: assert property (@(posedge clk) disable iff (rst)
    (bus_wr_en && bus_addr == ADDR_DATA && !seq_wr) |=> latch_q == $past(bus_wdata));

  a_r10_seq_wins: assert property (@(posedge clk) disable iff (rst)
    seq_wr |=> latch_q == $past(seq_data));
endmodule

// File: rtl/gpio_readmux.sv
module gpio_readmux
  import gpio_rmw_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_en,
  input  logic             rd_addr,
  input  logic [WIDTH-1:0] dir_q,
  input  logic [WIDTH-1:0] latch_q,
  input  logic [WIDTH-1:0] pin_sync,
  output logic [WIDTH-1:0] port_view,
  output logic [WIDTH-1:0] rdata
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign port_view[i] = dir_q[i] ? latch_q[i] : pin_sync[i];
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= (rd_addr == ADDR_DIR) ? dir_q : port_view;
  end

  a_r3_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));
endmodule

// File: rtl/gpio_bitseq.sv
module gpio_bitseq
  import gpio_rmw_pkg::*;
#(
  parameter int WIDTH = 8,
  localparam int BW   = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic             cmd_set,
  input  logic [BW-1:0]    cmd_bit,
  input  logic [WIDTH-1:0] port_view,
  output logic             busy,
  output logic             seq_wr,
  output logic [WIDTH-1:0] seq_data
);
  seq_state_t        state;
  logic [BW-1:0]     bit_q;
  logic              op_q;
  logic [WIDTH-1:0]  snap;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= SQ_IDLE;
      bit_q <= '0;
      op_q  <= 1'b0;
      snap  <= '0;
    end else begin
      case (state)
        SQ_IDLE: begin
          if (cmd_valid) begin
            bit_q <= cmd_bit;
            op_q  <= cmd_set;
            state <= SQ_READ;
          end
        end
        SQ_READ: begin
          snap  <= port_view;
          state <= SQ_MODIFY;
        end
        SQ_MODIFY: begin
          snap[bit_q] <= op_q;
          state       <= SQ_WRITE;
        end
        SQ_WRITE: state <= SQ_IDLE;
        default:  state <= SQ_IDLE;
      endcase
    end
  end

  assign busy     = (state != SQ_IDLE);
  assign seq_wr   = (state == SQ_WRITE);
  assign seq_data = snap;

  a_r8_busy_three: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |=> busy ##1 busy ##1 !busy);

  a_r9_reject_busy: assert property (@(posedge clk) disable iff (rst)
    (busy && cmd_valid) |=> ($stable(bit_q) && $stable(op_q)));

  a_r6_forced_bit: assert property (@(posedge clk) disable iff (rst)
    seq_wr |-> seq_data[bit_q] == op_q);
endmodule

// File: rtl/gpio_rmw_port.sv
module gpio_rmw_port #(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2,
  localparam int BW         = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_wr_en,
  input  logic             bus_rd_en,
  input  logic             bus_addr,
  input  logic [WIDTH-1:0] bus_wdata,
  output logic [WIDTH-1:0] bus_rdata,
  input  logic             cmd_valid,
  input  logic             cmd_set,
  input  logic [BW-1:0]    cmd_bit,
  output logic             cmd_busy,
  input  logic [WIDTH-1:0] pin_in,
  output logic [WIDTH-1:0] pin_out,
  output logic [WIDTH-1:0] pin_oe
);
  logic [WIDTH-1:0] pin_sync;
  logic [WIDTH-1:0] dir_q;
  logic [WIDTH-1:0] latch_q;
  logic [WIDTH-1:0] port_view;
  logic             seq_wr;
  logic [WIDTH-1:0] seq_data;

  gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_in(pin_in), .sync_out(pin_sync)
  );

  gpio_regs #(.WIDTH(WIDTH)) u_regs (
    .clk(clk), .rst(rst),
    .bus_wr_en(bus_wr_en), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .seq_wr(seq_wr), .seq_data(seq_data),
    .dir_q(dir_q), .latch_q(latch_q)
  );

  gpio_readmux #(.WIDTH(WIDTH)) u_rmux (
    .clk(clk), .rst(rst), .rd_en(bus_rd_en), .rd_addr(bus_addr),
    .dir_q(dir_q), .latch_q(latch_q), .pin_sync(pin_sync),
    .port_view(port_view), .rdata(bus_rdata)
  );

  gpio_bitseq #(.WIDTH(WIDTH)) u_seq (
    .clk(clk), .rst(rst),
    .cmd_valid(cmd_valid), .cmd_set(cmd_set), .cmd_bit(cmd_bit),
    .port_view(port_view),
    .busy(cmd_busy), .seq_wr(seq_wr), .seq_data(seq_data)
  );

  assign pin_oe  = dir_q;
  assign pin_out = latch_q & dir_q;

  a_r2_no_undriven_level: assert property (@(posedge clk) disable iff (rst)
    (pin_out & ~pin_oe) == '0);

  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!cmd_busy && pin_oe == '0));
endmodule

// File: tb/sim_gpio_rmw_port.sv
module sim_gpio_rmw_port;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_wr_en = 1'b0;
  logic       bus_rd_en = 1'b0;
  logic       bus_addr  = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       cmd_valid = 1'b0;
  logic       cmd_set   = 1'b0;
  logic [2:0] cmd_bit   = 3'd0;
  logic       cmd_busy;
  logic [7:0] pin_in    = 8'h00;
  logic [7:0] pin_out;
  logic [7:0] pin_oe;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  gpio_rmw_port u0 (
    .clk(clk), .rst(rst),
    .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cmd_valid(cmd_valid), .cmd_set(cmd_set), .cmd_bit(cmd_bit),
    .cmd_busy(cmd_busy),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  // {direction, latch, pins, {4'b0, op, bit}}
  localparam int NV = 8;
  localparam logic [31:0] VEC [NV] = '{
    {8'h3F, 8'h80, 8'h40, 8'h08},
    {8'hFF, 8'h00, 8'h00, 8'h0F},
    {8'hFF, 8'hFF, 8'h00, 8'h03},
    {8'h00, 8'h5A, 8'hA5, 8'h09},
    {8'h0F, 8'hF0, 8'hC3, 8'h02},
    {8'hF0, 8'h0F, 8'h3C, 8'h0C},
    {8'hAA, 8'h55, 8'hFF, 8'h00},
    {8'h81, 8'h7E, 8'h00, 8'h0F}
  };

  function automatic logic [7:0] rmw_model(input logic [7:0] d, input logic [7:0] l,
                                           input logic [7:0] p, input logic op,
                                           input logic [2:0] b);
    logic [7:0] v;
    v    = (d & l) | (~d & p);
    v[b] = op;
    return v;
  endfunction

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic bus_write(input logic a, input logic [7:0] d);
    bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr_en = 1'b0;
  endtask

  task automatic bus_read(input logic a, output logic [7:0] d);
    bus_rd_en = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd_en = 1'b0;
    d = bus_rdata;
  endtask

  task automatic run_cmd(input logic op, input logic [2:0] b);
    cmd_valid = 1'b1; cmd_set = op; cmd_bit = b;
    @(negedge clk);
    cmd_valid = 1'b0;
    while (cmd_busy) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] rd;
    int busy_cnt;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state
    check("R1 pin_oe", pin_oe, 8'h00);
    check("R1 pin_out", pin_out, 8'h00);
    check("R1 busy", {7'd0, cmd_busy}, 8'h00);
    bus_read(1'b1, rd);
    check("R1 dir read", rd, 8'h00);

    // R3: direction write and read back
    bus_write(1'b1, 8'h5C);
    check("R3 dir visible on pin_oe", pin_oe, 8'h5C);
    bus_read(1'b1, rd);
    check("R3 dir read", rd, 8'h5C);

    // R2: input bits undriven whatever the latch holds
    bus_write(1'b0, 8'hFF);
    check("R2 pin_out masked", pin_out, 8'h5C);

    // R5: synchroniser latency, all inputs
    bus_write(1'b1, 8'h00);
    pin_in = 8'h3C; bus_rd_en = 1'b1; bus_addr = 1'b0;
    @(negedge clk); check("R5 edge1 old", bus_rdata, 8'h00);
    @(negedge clk); check("R5 edge2 old", bus_rdata, 8'h00);
    @(negedge clk); check("R5 edge3 new", bus_rdata, 8'h3C);
    bus_rd_en = 1'b0;

    // Vector table: R2, R4, R6, R7
    for (int i = 0; i < NV; i++) begin
      logic [7:0] vd, vl, vp, ex;
      logic vo;
      logic [2:0] vb;
      vd = VEC[i][31:24]; vl = VEC[i][23:16]; vp = VEC[i][15:8];
      vo = VEC[i][3];     vb = VEC[i][2:0];
      ex = rmw_model(vd, vl, vp, vo, vb);
      bus_write(1'b1, vd);
      bus_write(1'b0, vl);
      pin_in = vp;
      repeat (3) @(negedge clk);
      run_cmd(vo, vb);
      check("R2 driven levels", pin_out & pin_oe, ex & vd);
      bus_read(1'b0, rd);
      check("R4 mixed read", rd, (vd & ex) | (~vd & vp));
      bus_write(1'b1, 8'hFF);
      bus_read(1'b0, rd);
      if (i == 0) check("R7 latch after set bit0", rd, 8'h41);
      else        check("R6 latch after rmw", rd, ex);
    end

    // R8 / R9: busy window and rejection of a second command
    bus_write(1'b1, 8'hFF);
    bus_write(1'b0, 8'h00);
    cmd_valid = 1'b1; cmd_set = 1'b1; cmd_bit = 3'd5;
    @(negedge clk);
    cmd_bit = 3'd2;            // still valid: must be ignored (R9)
    busy_cnt = 0;
    if (cmd_busy) busy_cnt++;
    @(negedge clk);
    cmd_valid = 1'b0;
    if (cmd_busy) busy_cnt++;
    @(negedge clk);
    if (cmd_busy) busy_cnt++;
    check("R8 latch unchanged while busy", pin_out, 8'h00);
    @(negedge clk);
    if (cmd_busy) busy_cnt++;
    check("R8 busy cycles", busy_cnt[7:0], 8'd3);
    check("R8 latch written at busy fall", pin_out, 8'h20);
    @(negedge clk);
    check("R9 second command ignored", pin_out, 8'h20);

    // R10: bus data write collides with sequencer write phase
    bus_write(1'b0, 8'h00);
    cmd_valid = 1'b1; cmd_set = 1'b1; cmd_bit = 3'd1;
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (2) @(negedge clk);
    bus_write(1'b0, 8'hAA);    // sampled at the write-phase edge
    bus_read(1'b0, rd);
    check("R10 sequencer wins", rd, 8'h02);
    bus_write(1'b0, 8'h11);
    bus_read(1'b0, rd);
    check("R3 data write when idle", rd, 8'h11);

    finish_run();
  end
endmodule